// File: doc/BRIEF.md
# Counting Ramp Converter Controller

This block is the digital half of a staircase-ramp analog-to-digital converter. An up-counter drives the code input of an external digital-to-analog converter. A single comparator bit reports whether the sampled analog level is still above that converter's output. While the bit is high, the count climbs one step per clock, so the analog output forms a rising staircase. When the bit drops, the count freezes. The frozen value is the conversion result, and a done flag is raised.

The comparator bit comes from the analog domain, so it first passes through a synchronizer chain of `SYNC_STAGES` flops. The controller waits for that chain to fill before it starts counting. Because of the chain, the result overshoots the analog threshold by `SYNC_STAGES` codes. If the comparator never trips, the counter stops at all ones and does not wrap. To start a new conversion, the system pulses the reset input. The reset clears the count and restarts the sequence.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, `dacCode`, `result` and `done` are all 0 after that edge.
- R2: After `rst` is released, `dacCode` stays 0 for the first `SYNC_STAGES` rising edges, whatever the comparator reports.
- R3: After the priming edges and before `done`, each rising edge either leaves `dacCode` unchanged or raises it by exactly 1, and never lowers it. It rises only when the synchronized comparator reads 1, where 1 means "analog level above the converter output".
- R4: For a constant analog level L (in code units), with the comparator defined as L > dacCode, the final result is 0 when L is 0 and min(L + `SYNC_STAGES`, 2^W − 1) otherwise.
- R5: `result` reads 0 until `done` rises. From that edge on, it equals the frozen count, and `dacCode` shows the same value.
- R6: The count saturates at 2^W − 1 and then raises `done`. It never wraps to 0 without a reset.
- R7: `done` rises on the same edge that counting stops and stays high until the next reset. While `done` is high, comparator activity has no effect on `dacCode` or `result`.
- R8: A reset pulse in the middle of a conversion abandons it. The next conversion starts again from 0.
- R9: A comparator fall takes `SYNC_STAGES` edges to reach the counter. If the comparator is first driven low while `dacCode` shows d, the result is d + `SYNC_STAGES`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset; also the restart pulse for each conversion |
| cmpAbove | input | 1 | Asynchronous comparator bit; 1 while the analog level exceeds the converter output |
| dacCode | output | W | Live count, fed to the external converter |
| result | output | W | Held conversion result, 0 until done |
| done | output | 1 | High from the edge on which counting stops until the next reset |

## Verification
The checker covers several rules on every cycle: the unit-step rule for the count, the zero window while the synchronizer fills, the freeze and stickiness of `done`, the tie between `result` and the held count, and the absence of wrap. Other behaviour depends on the analog level, so only the bench scenarios can show it. That includes the exact result value with the synchronizer overshoot, the result after a mid-conversion drop of the level, saturation when the level is beyond full scale, and the abandonment of a conversion by a restart pulse. A behavioural model with a queue for the synchronizer delay is compared against the outputs on every cycle.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;  // zero count and result
    logic inc;    // advance the count by one
    logic latch;  // capture the count as the result
  } rampStrobe_t;

  typedef enum logic [1:0] {
    ST_PRIME = 2'd0,
    ST_RUN   = 2'd1,
    ST_HOLD  = 2'd2
  } rampState_t;

endpackage

// File: rtl/ramp_sync.sv
module ramp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dIn,
  output logic dOut
);

  generate
    if (STAGES <= 1) begin : gSingle
      logic stage;
      always_ff @(posedge clk) begin
        if (rst) stage <= 1'b0;
        else     stage <= dIn;
      end
      assign dOut = stage;
    end else begin : gChain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], dIn};
      end
      assign dOut = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/ramp_ctrl.sv
module ramp_ctrl
  import ramp_adc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmpSync,
  input  logic        atMax,
  output rampStrobe_t strb,
  output logic        done
);

  localparam int PW = (SYNC_STAGES < 2) ? 1 : $clog2(SYNC_STAGES);
  localparam logic [PW-1:0] PRIME_LAST = PW'(SYNC_STAGES - 1);

  rampState_t      state;
  logic [PW-1:0]   primeCnt;
  logic            keepGoing;

  assign keepGoing = cmpSync && !atMax;

  always_comb begin
    strb.clear = rst;
    strb.inc   = (state == ST_RUN) && keepGoing;
    strb.latch = (state == ST_RUN) && !keepGoing;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_PRIME;
      primeCnt <= '0;
    end else begin
      case (state)
        ST_PRIME: begin
          if (primeCnt == PRIME_LAST) state <= ST_RUN;
          else                        primeCnt <= primeCnt + 1'b1;
        end
        ST_RUN:  if (strb.latch) state <= ST_HOLD;
        ST_HOLD: state <= ST_HOLD;
        default: state <= ST_PRIME;
      endcase
    end
  end

  assign done = (state == ST_HOLD);

endmodule

// File: rtl/ramp_datapath.sv
module ramp_datapath
  import ramp_adc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  rampStrobe_t   strb,
  output logic [W-1:0]  count,
  output logic [W-1:0]  heldRes,
  output logic          atMax
);

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      count   <= '0;
      heldRes <= '0;
    end else begin
      if (strb.inc)   count   <= count + 1'b1;
      if (strb.latch) heldRes <= count;
    end
  end

  assign atMax = &count;

endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
  import ramp_adc_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmpAbove,
  output logic [W-1:0] dacCode,
  output logic [W-1:0] result,
  output logic         done
);

  rampStrobe_t strb;
  logic        cmpSync;
  logic        atMax;

  ramp_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk (clk),
    .rst (rst),
    .dIn (cmpAbove),
    .dOut(cmpSync)
  );

  ramp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk    (clk),
    .rst    (rst),
    .cmpSync(cmpSync),
    .atMax  (atMax),
    .strb   (strb),
    .done   (done)
  );

  ramp_datapath #(.W(W)) uPath (
    .clk    (clk),
    .strb   (strb),
    .count  (dacCode),
    .heldRes(result),
    .atMax  (atMax)
  );

endmodule

// File: rtl/ramp_adc_checks.sv
module ramp_adc_checks #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] dacCode,
  input logic [W-1:0] result,
  input logic         done
);

  localparam logic [W-1:0] FULL = '1;

  logic seenRst = 1'b0;
  int   sinceRst = 0;

  always_ff @(posedge clk) begin
    if (rst) begin
      seenRst  <= 1'b1;
      sinceRst <= 0;
    end else if (sinceRst <= SYNC_STAGES) begin
      sinceRst <= sinceRst + 1;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (dacCode == '0 && result == '0 && !done));

  p_prime_zero_r2: assert property (@(posedge clk) disable iff (rst || !seenRst)
    (sinceRst <= SYNC_STAGES) |-> (dacCode == '0 && !done));

  p_unit_step_r3: assert property (@(posedge clk) disable iff (rst || !seenRst)
    (!$past(rst) && dacCode != $past(dacCode)) |-> (dacCode == $past(dacCode) + 1'b1));

  p_result_tie_r5: assert property (@(posedge clk) disable iff (rst || !seenRst)
    done ? (result == dacCode) : (result == '0));

  p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst || !seenRst)
    (!$past(rst) && $past(dacCode) == FULL) |-> (dacCode == FULL));

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst || !seenRst)
    done |=> (done && $stable(dacCode) && $stable(result)));

endmodule

bind ramp_adc_ctrl ramp_adc_checks #(.W(W), .SYNC_STAGES(SYNC_STAGES)) uChecks (
  .clk    (clk),
  .rst    (rst),
  .dacCode(dacCode),
  .result (result),
  .done   (done)
);

// File: tb/sim_ramp_adc_ctrl.sv
`timescale 1ns/1ps
module sim_ramp_adc_ctrl;

  localparam int W    = 8;
  localparam int SYNC = 2;
  localparam int FULL = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmpAbove;
  logic [W-1:0] dacCode;
  logic [W-1:0] result;
  logic         done;

  int   level = 0;
  logic ovrOn = 1'b0;
  logic ovrVal = 1'b0;
  logic chkOn = 1'b0;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  // analog model: comparator against the live code
  assign cmpAbove = ovrOn ? ovrVal : (level > int'(dacCode));

  ramp_adc_ctrl #(.W(W), .SYNC_STAGES(SYNC)) u0 (
    .clk     (clk),
    .rst     (rst),
    .cmpAbove(cmpAbove),
    .dacCode (dacCode),
    .result  (result),
    .done    (done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mCnt = 0, mRes = 0, mPrime = SYNC;
  bit mDone = 0;
  bit pipe[$];

  always @(posedge clk) begin
    if (rst) begin
      mCnt = 0; mRes = 0; mDone = 0; mPrime = SYNC;
      pipe.delete();
      for (int i = 0; i < SYNC; i++) pipe.push_back(1'b0);
    end else begin
      bit seen;
      seen = pipe[0];
      if (mPrime > 0) mPrime--;
      else if (!mDone) begin
        if (seen && mCnt < FULL) mCnt++;
        else begin mDone = 1; mRes = mCnt; end
      end
      pipe.push_back(cmpAbove === 1'b1);
      void'(pipe.pop_front());
    end
  end

  always @(negedge clk) begin
    if (chkOn) begin
      check(int'(dacCode) == mCnt, "R3 model dacCode", int'(dacCode), mCnt);
      check(int'(result) == mRes, "R5 model result", int'(result), mRes);
      check(done == mDone, "R7 model done", int'(done), int'(mDone));
    end
  end

  function automatic int expect_res(input int lv);
    if (lv <= 0) return 0;
    return (lv + SYNC > FULL) ? FULL : lv + SYNC;
  endfunction

  task automatic pulse_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(dacCode == '0 && result == '0 && !done, "R1 reset state", int'(dacCode), 0);
    rst = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit && !done; i++) @(negedge clk);
  endtask

  task automatic convert(input int lv, input string tag);
    level = lv;
    pulse_reset();
    for (int i = 0; i < SYNC; i++) begin
      @(negedge clk);
      check(dacCode == '0, "R2 priming zero", int'(dacCode), 0);
    end
    wait_done(FULL + 20);
    check(done == 1'b1, {tag, " done"}, int'(done), 1);
    check(int'(result) == expect_res(lv), {tag, " result"}, int'(result), expect_res(lv));
    check(result == dacCode, "R5 result equals held code", int'(result), int'(dacCode));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks + 1 - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    level = 0;
    repeat (3) @(negedge clk);
    chkOn = 1'b1;
    check(dacCode == '0 && !done, "R1 initial reset", int'(dacCode), 0);

    convert(0,   "R4 level zero");
    convert(1,   "R4 level one");
    convert(37,  "R4 level mid");
    convert(200, "R4 level high");

    // R7: comparator activity after done is ignored
    ovrOn = 1'b1; ovrVal = 1'b1;
    repeat (20) @(negedge clk);
    check(int'(result) == expect_res(200), "R7 result frozen", int'(result), expect_res(200));
    check(done == 1'b1, "R7 done sticky", int'(done), 1);
    ovrVal = 1'b0;
    repeat (3) @(negedge clk);
    ovrVal = 1'b1;
    repeat (3) @(negedge clk);
    check(int'(dacCode) == expect_res(200), "R7 code frozen", int'(dacCode), expect_res(200));
    ovrOn = 1'b0;

    // R6: saturation at full scale and beyond
    convert(FULL - 1, "R6 near full");
    convert(FULL + 500, "R6 beyond full");
    repeat (10) @(negedge clk);
    check(int'(dacCode) == FULL, "R6 no wrap", int'(dacCode), FULL);

    // R8: restart mid conversion
    level = 220;
    pulse_reset();
    repeat (60) @(negedge clk);
    check(!done && dacCode != '0, "R8 conversion underway", int'(dacCode), 1);
    convert(10, "R8 after restart");

    // R9: level drops during the ramp
    begin
      int d;
      level = 230;
      pulse_reset();
      while (int'(dacCode) < 50) @(negedge clk);
      d = int'(dacCode);
      level = 5;
      wait_done(40);
      check(int'(result) == d + SYNC, "R9 sync delay on drop", int'(result), d + SYNC);
    end

    // R3: single step from zero once priming ends
    level = 100;
    pulse_reset();
    repeat (SYNC + 1) @(negedge clk);
    check(int'(dacCode) == 1, "R3 first step", int'(dacCode), 1);
    wait_done(FULL + 20);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule